// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is a small sum-of-products logic cell. It takes eighteen routed input signals and forms product terms from a programmable AND plane. Each term can use either polarity of each input. Four outputs are built from these terms. Each output either takes the OR of its own group of four terms (the short path), or takes an OR of any selected subset of twenty terms and passes it through an XOR stage. The second XOR operand is a constant bit or any one of the twenty terms. This lets an output be inverted or combine two functions as a parity.

Each output is combinational or registered, chosen by its own setting. Three extra product terms control the registers and the downstream I/O. One can reset the registers asynchronously, one can clock the registers in place of the block clock, and one drives an output-enable signal. The configuration vector is a static input. It is captured on every rising clock edge while the active-low external reset is held low. The external reset also clears all output registers asynchronously.

Top module: `plb_cell`

## Requirements
- R1: Product term t (0..22) takes its literals from configuration bits starting at t*36. For input j, bit t*36+2j enables the true literal and bit t*36+2j+1 enables the complemented literal. The term is the AND of its enabled literals, so a term with no enabled literal is 1 and a term that enables both polarities of one input is 0.
- R2: Output i has a field of 29 bits at base 828+29*i. Bits [19:0] of the field are an OR mask over terms 0..19. Bit 21 selects the XOR operand: 0 takes the constant in bit 22, and 1 takes the term whose index is in bits [27:23]. An index of 20 or more reads as 0. The full-path value is the masked OR XOR that operand.
- R3: When bit 20 of the output field is set, the output value is the OR of terms 4i..4i+3, with no XOR applied.
- R4: When bit 28 of the output field is set, the output follows its value combinationally: an input change shows at the output with no clock edge.
- R5: When bit 28 is clear and the clock-select bit is 0, the output shows the value its logic had just before the last rising edge of clk.
- R6: While rst_n is low, all output registers read 0 at once, and cfg_i is captured on each rising edge of clk. After release, registered outputs stay 0 until the first capturing edge.
- R7: When the reset-enable bit (bit 945) is 1, term 20 clears the output registers asynchronously while it is 1.
- R8: When the clock-select bit (bit 944) is 1, the registers capture on the rising edge of term 21 only. Edges of clk and input changes without such an edge leave the registered outputs unchanged.
- R9: oe_o equals term 22 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; default register clock and configuration capture clock |
| rst_n | input | 1 | Active-low external reset; clears registers, enables configuration capture |
| x_i | input | 18 | Routed logic inputs |
| cfg_i | input | 946 | Static configuration vector |
| out_o | output | 4 | Logic outputs, combinational or registered per output |
| oe_o | output | 1 | Output enable formed by product term 22 |

## Verification
Combinational outputs, the output enable and the effect of either asynchronous reset are due as soon as the inputs settle. The bench drives inputs just after a falling clock edge and samples 1 ns later, inside the same low phase. A registered output is due only after the next rising edge of its register clock, so the bench's own register model updates at each rising edge and is compared in the following low phase. In term-clock mode the bench makes the rising edge itself with one input bit and checks both before and after that edge. It also checks that clk edges between them change nothing.

// File: rtl/plb_cell.sv
module plb_cell #(
  parameter int N_IN   = 18,
  parameter int N_OUT  = 4,
  parameter int N_PT   = 20,
  parameter int N_FAST = 4,
  localparam int N_TERM = N_PT + 3,
  localparam int IDXW   = $clog2(N_PT),
  localparam int TW     = 2 * N_IN,
  localparam int OW     = N_PT + IDXW + 4,
  localparam int OB     = N_TERM * TW,
  localparam int GB     = OB + N_OUT * OW,
  localparam int CFG_W  = GB + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  x_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [N_OUT-1:0] out_o,
  output logic             oe_o
);

  logic [CFG_W-1:0]  cfg_q;
  logic [N_TERM-1:0] pt;
  logic [N_OUT-1:0]  comb, q, byp;
  logic              clk_sel, rst_en, reg_clk, arst_n;

  always_ff @(posedge clk)
    if (!rst_n) cfg_q <= cfg_i;

  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      pt[t] = 1'b1;
      for (int j = 0; j < N_IN; j++) begin
        if (cfg_q[t*TW + 2*j]     && !x_i[j]) pt[t] = 1'b0;
        if (cfg_q[t*TW + 2*j + 1] &&  x_i[j]) pt[t] = 1'b0;
      end
    end
  end

  assign clk_sel = cfg_q[GB];
  assign rst_en  = cfg_q[GB+1];
  assign reg_clk = clk_sel ? pt[N_PT+1] : clk;
  assign arst_n  = rst_n & ~(rst_en & pt[N_PT]);
  assign oe_o    = pt[N_PT+2];

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam int B = OB + i * OW;
    logic [N_PT-1:0]      mask;
    logic [IDXW-1:0]      idx;
    logic [2**IDXW-1:0]   pool;
    logic                 fast, xop;

    assign mask = cfg_q[B +: N_PT];
    assign fast = cfg_q[B + N_PT];
    assign idx  = cfg_q[B + N_PT + 3 +: IDXW];
    assign byp[i] = cfg_q[B + N_PT + 3 + IDXW];

    always_comb begin
      pool = '0;
      pool[N_PT-1:0] = pt[N_PT-1:0];
    end

    assign xop = cfg_q[B + N_PT + 1] ? pool[idx] : cfg_q[B + N_PT + 2];
    assign comb[i] = fast ? |pt[i*N_FAST +: N_FAST]
                          : ((|(pt[N_PT-1:0] & mask)) ^ xop);

    // R5
    reg_capture_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!byp[i] && !clk_sel) |=> (out_o[i] == $past(comb[i])));

    // R3
    fast_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && byp[i] && (pt[i*N_FAST +: N_FAST] == '0)) |-> !out_o[i]);
  end

  always_ff @(posedge reg_clk or negedge arst_n)
    if (!arst_n) q <= '0;
    else         q <= comb;

  assign out_o = (byp & comb) | (~byp & q);

  // R9
  oe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[(N_PT+2)*TW +: TW] == '0) |-> oe_o);

  // R7
  term_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_en && pt[N_PT]) |-> ((out_o & ~byp) == '0));

endmodule

// File: tb/tb_plb_cell.sv
module tb_plb_cell;
  localparam int PERIOD = 10;
  localparam int N_IN = 18, N_OUT = 4, N_PT = 20, N_TERM = 23;
  localparam int TW = 36, OW = 29, OB = 828, GB = 944, CFG_W = 946;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0]  x = '0;
  logic [CFG_W-1:0] cfg = '0;
  logic [N_OUT-1:0] out;
  logic oe;
  int checks = 0, fails = 0;
  logic [N_OUT-1:0] qm = '0;

  plb_cell dut (.clk(clk), .rst_n(rst_n), .x_i(x), .cfg_i(cfg), .out_o(out), .oe_o(oe));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [N_TERM-1:0] m_terms(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] xv);
    logic [N_TERM-1:0] r;
    for (int t = 0; t < N_TERM; t++) begin
      r[t] = 1'b1;
      for (int j = 0; j < N_IN; j++)
        if ((c[t*TW+2*j] && !xv[j]) || (c[t*TW+2*j+1] && xv[j])) r[t] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] m_comb(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] xv);
    logic [N_TERM-1:0] p;
    logic [N_OUT-1:0] r;
    p = m_terms(c, xv);
    for (int i = 0; i < N_OUT; i++) begin
      int b;
      logic s, op;
      int k;
      b = OB + i*OW;
      if (c[b+20]) r[i] = p[4*i] | p[4*i+1] | p[4*i+2] | p[4*i+3];
      else begin
        s = 1'b0;
        for (int t = 0; t < N_PT; t++) if (c[b+t] && p[t]) s = 1'b1;
        k = int'(c[b+23 +: 5]);
        op = c[b+21] ? ((k < N_PT) ? p[k] : 1'b0) : c[b+22];
        r[i] = s ^ op;
      end
    end
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] m_byp(input logic [CFG_W-1:0] c);
    logic [N_OUT-1:0] r;
    for (int i = 0; i < N_OUT; i++) r[i] = c[OB + i*OW + 28];
    return r;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    qm = '0;
  endtask

  task automatic rand_cfg();
    cfg = '0;
    for (int t = 0; t < N_TERM; t++)
      for (int j = 0; j < TW; j++)
        if ($urandom % 12 == 0) cfg[t*TW + j] = 1'b1;
    for (int i = 0; i < N_OUT; i++) begin
      int b;
      b = OB + i*OW;
      cfg[b +: 20] = 20'($urandom) & 20'($urandom);
      cfg[b+20] = ($urandom % 3 == 0);
      cfg[b+21] = $urandom % 2;
      cfg[b+22] = $urandom % 2;
      cfg[b+23 +: 5] = 5'($urandom % 32);
      cfg[b+28] = $urandom % 2;
    end
    cfg[GB]   = 1'b0;
    cfg[GB+1] = ($urandom % 3 == 0);
  endtask

  task automatic check_now();
    logic [N_OUT-1:0] c, b;
    logic [N_TERM-1:0] p;
    logic ract;
    c = m_comb(cfg, x);
    b = m_byp(cfg);
    p = m_terms(cfg, x);
    ract = cfg[GB+1] && p[20];
    if (ract) qm = '0;
    for (int i = 0; i < N_OUT; i++) begin
      if (b[i]) chk(cfg[OB+i*OW+20] ? "R3" : "R2", out[i], c[i]);
      else if (ract) chk("R7", out[i], 1'b0);
      else chk("R5", out[i], qm[i]);
    end
    chk("R9", oe, p[22]);
  endtask

  task automatic run_random(input int n);
    for (int k = 0; k < n; k++) begin
      logic [N_OUT-1:0] c;
      logic ract;
      #1;
      check_now();
      c = m_comb(cfg, x);
      ract = cfg[GB+1] && m_terms(cfg, x)[20];
      @(posedge clk);
      if (!ract) qm = c;
      @(negedge clk);
      x = 18'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'h1c3b));
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N_OUT-1:0] b, c;
    // Directed: R1 empty and contradictory terms, R2 inversion and large index, R4
    cfg = '0;
    cfg[OB + 0*OW + 20] = 1'b1; cfg[OB + 0*OW + 28] = 1'b1;
    cfg[OB + 1*OW + 4]  = 1'b1; cfg[OB + 1*OW + 28] = 1'b1;
    cfg[4*TW + 10] = 1'b1; cfg[4*TW + 11] = 1'b1;
    cfg[OB + 2*OW + 22] = 1'b1; cfg[OB + 2*OW + 28] = 1'b1;
    cfg[OB + 3*OW + 9]  = 1'b1; cfg[OB + 3*OW + 21] = 1'b1;
    cfg[OB + 3*OW + 23 +: 5] = 5'd25; cfg[OB + 3*OW + 28] = 1'b1;
    cfg[9*TW + 6] = 1'b1;
    x = '0;
    apply_reset();
    #1;
    chk("R1", out[0], 1'b1);
    chk("R1", out[1], 1'b0);
    chk("R2", out[2], 1'b1);
    chk("R2", out[3], 1'b0);
    chk("R9", oe, 1'b1);
    x[3] = 1'b1; x[5] = 1'b1;
    #1;
    chk("R4", out[3], 1'b1);
    chk("R1", out[1], 1'b0);
    x[3] = 1'b0;
    #1;
    chk("R4", out[3], 1'b0);

    // Random configurations with the block clock
    for (int n = 0; n < 60; n++) begin
      rand_cfg();
      x = 18'($urandom);
      apply_reset();
      #1;
      b = m_byp(cfg);
      for (int i = 0; i < N_OUT; i++)
        if (!b[i]) chk("R6", out[i], 1'b0);
      run_random(30);
      if (n % 10 == 3) begin
        #1;
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < N_OUT; i++)
          if (!b[i]) chk("R6", out[i], 1'b0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        qm = '0;
        run_random(5);
      end
    end

    // Term-driven register clock
    for (int n = 0; n < 6; n++) begin
      rand_cfg();
      for (int t = 0; t < N_TERM; t++) cfg[t*TW +: 4] = '0;
      cfg[21*TW +: TW] = '0;
      cfg[21*TW] = 1'b1;
      cfg[20*TW +: TW] = '0;
      for (int i = 0; i < N_OUT; i++) cfg[OB + i*OW + 28] = 1'b0;
      cfg[GB] = 1'b1; cfg[GB+1] = 1'b0;
      x = '0;
      apply_reset();
      for (int k = 0; k < 10; k++) begin
        x = 18'($urandom) & ~18'h1;
        #1;
        for (int i = 0; i < N_OUT; i++) chk("R8", out[i], qm[i]);
        @(posedge clk);
        @(negedge clk);
        #1;
        for (int i = 0; i < N_OUT; i++) chk("R8", out[i], qm[i]);
        x[0] = 1'b1;
        #1;
        qm = m_comb(cfg, x);
        for (int i = 0; i < N_OUT; i++) chk("R8", out[i], qm[i]);
        x = 18'($urandom) | 18'h1;
        c = m_comb(cfg, x);
        #1;
        for (int i = 0; i < N_OUT; i++) chk("R8", out[i], qm[i]);
        @(negedge clk);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule